// File: doc/BRIEF.md
# Overlapped Reply Pulse Edge Splitter

This block watches a single-bit thresholded video signal, already synchronous to the system clock, one sample per clock. It turns each high run of that signal into a set of one-clock strobes. The actual leading edge marks the first high sample. The actual trailing edge marks the first low sample after the run. A run longer than one standard reply pulse is taken to be two or more overlapped replies, so the block also marks the leading edges hidden inside it. A pseudo leading edge sits one standard width before the trailing edge. Extra leading edges follow the actual leading edge at standard-width spacing. Downstream reply decoders then see every pulse start, not only the first.

The video input is a free-running sample stream. Every clock carries one sample and the block never stalls, so there is no valid/ready handshake and no back-pressure. A pseudo edge can only be placed once the trailing edge has been seen. For that reason all four strobes pass through one shared look-ahead pipeline and come out with the same fixed latency. With the default standard width of 4 samples, a strobe that belongs to a sample taken at rising edge m is high during the clock that follows rising edge m+5.

Top module: `pulse_edge_splitter`

## Requirements
- R1: While reset is asserted and after it is released, all four strobes are low until the video produces an edge that the rules below report.
- R2: A high sample that follows a low sample gives a one-cycle lead strobe, STD_W+1 clocks after that sample was captured.
- R3: The first low sample after a high run gives a one-cycle trail strobe with the same latency as R2.
- R4: At most one of the four strobes is high in any cycle, and each is one cycle wide.
- R5: A run of STD_W samples or fewer (default 4) gives neither a pseudo strobe nor an extra strobe.
- R6: A run longer than STD_W samples gives exactly one pseudo strobe, STD_W cycles before its trail strobe (run start + width − STD_W in sample positions).
- R7: In a run starting at sample s with width W, an extra strobe is given at each position s+k·STD_W (k ≥ 1) that lies strictly before the pseudo position s+W−STD_W. Runs of 5 to 8 samples therefore give none, and a 9-sample run gives one.
- R8: A run that is already high when reset is released gives no strobe of any kind, including its trailing edge. Runs that begin after a low sample has been seen are handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one video sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears the pipeline and disarms the input |
| vid_i | input | 1 | Thresholded video sample |
| lead_o | output | 1 | Actual leading-edge strobe |
| trail_o | output | 1 | Actual trailing-edge strobe |
| pseudo_o | output | 1 | Pseudo leading-edge strobe for an overlapped run |
| extra_o | output | 1 | Extra leading-edge strobe for a long overlapped run |

## Verification
The bench sweeps run widths from 1 to 20 samples, separated by gaps of 1, 2 and 5 samples. It predicts every strobe position from the run start and width. The widths that matter most are 4 and 5, where the pseudo edge switches on, and 8 and 9, where the first extra edge appears. An off-by-one in the width compare would give a pseudo edge for a plain reply or drop one for a 5-sample overlap. A wrong extra-edge bound would give an extra edge that coincides with the pseudo edge at width 8. One-sample gaps check that a trail strobe and the next lead strobe land on consecutive cycles without merging. A run held high across reset release checks that the arming logic suppresses both its leading and its trailing strobe. A design without that logic would report a false leading edge at release.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
    logic pseudo;
    logic extra;
  } pes_strobe_t;
endpackage

// File: rtl/pes_arm_sync.sv
module pes_arm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic vid_i,
  output logic smp_o
);
  // Input is ignored until a low sample has been seen after reset.
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      smp_o   <= 1'b0;
    end else begin
      armed_q <= armed_q | ~vid_i;
      smp_o   <= vid_i & armed_q;
    end
  end
endmodule

// File: rtl/pes_tap_line.sv
module pes_tap_line #(
  parameter int DEPTH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [DEPTH:0] tap_o
);
  // tap_o[0] is the newest sample, tap_o[k] is the sample from k clocks earlier.
  logic [DEPTH:1] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[DEPTH-1:1], din};
  end

  assign tap_o = {sr_q, din};
endmodule

// File: rtl/pes_overlap_infer.sv
module pes_overlap_infer
  import pes_pkg::*;
#(
  parameter int STD_W = 4,
  localparam int PW   = (STD_W > 2) ? $clog2(STD_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STD_W+1:0] tap_i,
  output pes_strobe_t      strobe_o
);
  // Decisions are made for the sample at tap STD_W, with STD_W samples of look-ahead.
  logic          cur, prv;
  logic          ahead_hi, run_hi;
  logic [PW-1:0] ph_q, ph_now;

  assign cur = tap_i[STD_W];
  assign prv = tap_i[STD_W+1];

  // All samples from the newest up to (not including) the decision point are high.
  assign ahead_hi = &tap_i[STD_W-1:0];
  // The run ended one sample ago and lasted at least STD_W+1 samples.
  assign run_hi   = &tap_i[STD_W+1:1];

  always_comb begin
    if (cur && prv) ph_now = (ph_q == PW'(STD_W - 1)) ? '0 : ph_q + 1'b1;
    else            ph_now = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_now;
  end

  always_comb begin
    strobe_o.lead   = cur & ~prv;
    strobe_o.trail  = ~cur & prv;
    strobe_o.pseudo = ~tap_i[0] & run_hi;
    strobe_o.extra  = cur & prv & ahead_hi & (ph_now == '0);
  end
endmodule

// File: rtl/pes_strobe_out.sv
module pes_strobe_out
  import pes_pkg::*;
#(
  parameter int STD_W = 4,
  localparam int CW   = $clog2(STD_W + 2)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pes_strobe_t strobe_i,
  output pes_strobe_t strobe_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) strobe_o <= '0;
    else        strobe_o <= strobe_i;
  end

  // Checker state: countdown from a pseudo strobe, and distance since the last lead or extra.
  logic [CW-1:0] pend_q, since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      since_q <= '0;
    end else begin
      if (strobe_o.pseudo)    pend_q <= CW'(STD_W);
      else if (pend_q != '0)  pend_q <= pend_q - 1'b1;
      if (strobe_o.lead || strobe_o.extra) since_q <= CW'(1);
      else if (since_q != '0 && since_q < CW'(STD_W + 1)) since_q <= since_q + 1'b1;
    end
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe_o.lead, strobe_o.trail, strobe_o.pseudo, strobe_o.extra}));

  // R2
  lead_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o.lead |=> !strobe_o.lead);

  // R3
  trail_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o.trail |=> !strobe_o.trail);

  // R6
  pseudo_to_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == CW'(1)) |-> strobe_o.trail);

  // R6
  no_early_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q > CW'(1)) |-> !strobe_o.trail);

  // R7
  extra_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o.extra |-> (since_q == CW'(STD_W)));
endmodule

// File: rtl/pulse_edge_splitter.sv
module pulse_edge_splitter
  import pes_pkg::*;
#(
  parameter int STD_W  = 4,
  localparam int DEPTH = STD_W + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vid_i,
  output logic lead_o,
  output logic trail_o,
  output logic pseudo_o,
  output logic extra_o
);
  logic             smp;
  logic [DEPTH:0]   taps;
  pes_strobe_t      strobe_c, strobe_q;

  pes_arm_sync u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .vid_i (vid_i),
    .smp_o (smp)
  );

  pes_tap_line #(.DEPTH(DEPTH)) u_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (smp),
    .tap_o (taps)
  );

  pes_overlap_infer #(.STD_W(STD_W)) u_infer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap_i    (taps),
    .strobe_o (strobe_c)
  );

  pes_strobe_out #(.STD_W(STD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_c),
    .strobe_o (strobe_q)
  );

  assign lead_o   = strobe_q.lead;
  assign trail_o  = strobe_q.trail;
  assign pseudo_o = strobe_q.pseudo;
  assign extra_o  = strobe_q.extra;
endmodule

// File: tb/tb_pulse_edge_splitter.sv
module tb_pulse_edge_splitter;
  localparam int SW  = 4;
  localparam int LAT = SW + 2;   // from drive negedge to observing negedge
  localparam int NS  = 800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid = 1'b1;
  logic lead, trail, pseudo, extra;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit stim  [NS];
  bit e_ld  [NS];
  bit e_tr  [NS];
  bit e_ps  [NS];
  bit e_ex  [NS];
  int cat   [NS];   // 0 normal, 1 short run, 2 run high at reset release

  always #10 clk = ~clk;

  pulse_edge_splitter #(.STD_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .vid_i(vid),
    .lead_o(lead), .trail_o(trail), .pseudo_o(pseudo), .extra_o(extra)
  );

  task automatic chk(input string req, input string what, input int idx,
                     input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at sample %0d: actual %0b expected %0b", req, what, idx, act, exp);
    end
  endtask

  initial begin
    int p;
    p = 0;
    for (int i = 0; i < NS; i++) begin
      stim[i] = 0; e_ld[i] = 0; e_tr[i] = 0; e_ps[i] = 0; e_ex[i] = 0; cat[i] = 0;
    end
    for (int i = 0; i < 12; i++) stim[i] = 1;   // high across reset release (R8)
    p = 20;
    for (int w = 1; w <= 20; w++) begin
      for (int g = 0; g < 3; g++) begin
        for (int k = 0; k < w; k++) stim[p + k] = 1;
        p = p + w + ((g == 0) ? 1 : (g == 1) ? 2 : 5);
      end
    end
    // expected strobes computed from run start and width
    for (int i = 0; i < NS; i++) begin
      if (stim[i] && (i == 0 || !stim[i-1])) begin
        int w;
        w = 0;
        while (i + w < NS && stim[i + w]) w++;
        if (i == 0) begin
          for (int k = 0; k <= w; k++) cat[k] = 2;
        end else begin
          e_ld[i] = 1;
          e_tr[i + w] = 1;
          if (w <= SW) for (int k = 0; k <= w; k++) cat[i + k] = 1;
          if (w > SW) e_ps[i + w - SW] = 1;
          for (int k = 1; i + k*SW < i + w - SW; k++) e_ex[i + k*SW] = 1;
        end
      end
    end

    // R1: outputs held low in reset with video high
    repeat (4) begin
      @(negedge clk);
      chk("R1", "lead in reset", -1, lead, 1'b0);
      chk("R1", "trail in reset", -1, trail, 1'b0);
      chk("R1", "pseudo in reset", -1, pseudo, 1'b0);
      chk("R1", "extra in reset", -1, extra, 1'b0);
    end

    for (int j = 0; j < NS + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        int m;
        m = j - LAT;
        if (cat[m] == 2) begin
          chk("R8", "lead", m, lead, 1'b0);
          chk("R8", "trail", m, trail, 1'b0);
          chk("R8", "pseudo", m, pseudo, 1'b0);
          chk("R8", "extra", m, extra, 1'b0);
        end else begin
          chk("R2", "lead", m, lead, e_ld[m]);
          chk("R3", "trail", m, trail, e_tr[m]);
          if (cat[m] == 1) begin
            chk("R5", "pseudo", m, pseudo, 1'b0);
            chk("R5", "extra", m, extra, 1'b0);
          end else begin
            chk("R6", "pseudo", m, pseudo, e_ps[m]);
            chk("R7", "extra", m, extra, e_ex[m]);
          end
        end
        chk("R4", "strobe count", m, ($countones({lead, trail, pseudo, extra}) > 1), 1'b0);
        if (m < 20) chk("R1", "idle after reset", m, lead | trail | pseudo | extra, 1'b0);
      end
      if (j == 0) rst_n = 1'b1;
      vid = (j < NS) ? stim[j] : 1'b0;
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule